// File: doc/BRIEF.md
# Two-Stage Converter Duty Post-Processor

This block sits between a control-law evaluator and a pair of PWM modulators for a two-stage (step-down then step-up) DC-DC converter. It turns one scalar control value `u`, the desired stage-one voltage product in volts, and the measured supply voltage `vs` into two duty-cycle commands. The stage-one duty is `u / vs`. No divider is used. A serial reciprocal engine forms `1/vs` while the control law is still running. One multiply then scales `u` by that reciprocal.

The stage-two duty does not depend on `u`. A linear search over six supply-voltage ranges picks it, and the value comes from a clamped formula: `min(1.0, 0.95 * lowerBound / 20 V)`. The division by the fixed 20 V reference becomes a multiply by a constant reciprocal.

Both results wait in a pending buffer. They reach the modulators only on a sampling-synchronisation strobe, so both duties change together and only at sampling instants.

Top module: `dual_duty_shaper`

## Requirements
- R1: After reset `duty1Out` and `duty2Out` are 0 and `doneOut` is 0.
- R2: Voltages are unsigned with 8 fractional bits and duties are unsigned with 12 fractional bits, so 4096 means 1.0. Stage-one duty is `min(4096, (ctrlVal * floor(2^24 / vsC)) >> 12)`, with `vsC` the captured supply code after the clamp of R3.
- R3: A supply code below 2560 (10 V) is treated as 2560 for both the reciprocal and the range search.
- R4: The range index is the highest range whose lower bound is at or below `vsC`. The lower bounds are 10, 12, 14, 16, 18 and 21 V (codes 2560, 3072, 3584, 4096, 4608 and 5376). A supply exactly on a bound selects the upper range. Any supply at or above 21 V selects the last range.
- R5: Stage-two duty codes for ranges 0 to 5 are 1945, 2334, 2723, 3112, 3502 and 4085. Each is `(lowerVolts * 3891 * 3277) >> 16`, capped at 4096.
- R6: When `ctrlVal` is larger than the supply, stage-one duty saturates at 4096.
- R7: `startIn` captures `supplyV`. `doneOut` rises after the 26th rising edge following the start edge. `ctrlVal` is sampled on that 26th edge, so the evaluator has 25 cycles to produce it.
- R8: `duty1Out` and `duty2Out` change only on an edge where `syncIn` is high while `doneOut` is high. On every other edge they hold.
- R9: Such a sync edge copies both pending duties to the outputs in the same edge and clears `doneOut`.
- R10: `startIn` at any time clears `doneOut` on the next edge, discards the pending or partial result and restarts the computation. A sync before the new result leaves the outputs unchanged.
- R11: `syncIn` while `doneOut` is low has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Capture supply voltage and begin a new computation |
| ctrlVal | input | 14 | Control value u, volts, Q8, sampled at the multiply cycle |
| supplyV | input | 14 | Measured supply voltage, Q8 |
| syncIn | input | 1 | Sampling-synchronisation strobe |
| duty1Out | output | 13 | Applied stage-one duty, Q12 |
| duty2Out | output | 13 | Applied stage-two duty, Q12 |
| doneOut | output | 1 | Both pending duties are ready and not yet applied |

## Verification
The bench builds the block with its defaults: a 14-bit Q8 voltage format, Q12 duties, six ranges and a 24-bit reciprocal shift. That shift gives a 26-cycle start-to-done latency, short enough to run many captures, restarts in mid-computation and sync strobes before, at and after completion. The 14-bit supply range reaches codes below the 10 V clamp and above the top bound, as well as codes exactly on and one LSB under each range bound. Control values above the supply exercise stage-one saturation.

// File: rtl/dds_pkg.sv
package dds_pkg;

  localparam int VOLT_W      = 14;
  localparam int VOLT_FRAC   = 8;
  localparam int DUTY_FRAC   = 12;
  localparam int RECIP_SHIFT = 24;
  localparam int NUM_RANGES  = 6;

  localparam int unsigned RANGE_LO_V [NUM_RANGES] = '{10, 12, 14, 16, 18, 21};

  localparam int unsigned BETA_Q12      = 3891;
  localparam int unsigned REF_RECIP_Q16 = 3277;

  typedef struct packed {
    logic capture;
    logic divStep;
    logic mulLoad;
    logic apply;
  } ctrlStrobes_t;

endpackage

// File: rtl/dds_ctrl.sv
module dds_ctrl
  import dds_pkg::*;
#(
  parameter int DIV_STEPS = RECIP_SHIFT + 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startIn,
  input  logic         syncIn,
  output ctrlStrobes_t strobes,
  output logic         doneOut
);

  localparam int CNT_W = $clog2(DIV_STEPS + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_DIV, ST_MUL} ctrlState_t;

  ctrlState_t state;
  logic [CNT_W-1:0] stepCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
    end else if (startIn) begin
      state   <= ST_DIV;
      stepCnt <= '0;
    end else begin
      case (state)
        ST_DIV: begin
          if (stepCnt == CNT_W'(DIV_STEPS - 1)) begin
            state <= ST_MUL;
          end
          stepCnt <= stepCnt + 1'b1;
        end
        ST_MUL:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.capture = startIn;
    strobes.divStep = (state == ST_DIV) && !startIn;
    strobes.mulLoad = (state == ST_MUL) && !startIn;
    strobes.apply   = syncIn && doneOut;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneOut <= 1'b0;
    end else if (startIn) begin
      doneOut <= 1'b0;
    end else if (strobes.mulLoad) begin
      doneOut <= 1'b1;
    end else if (strobes.apply) begin
      doneOut <= 1'b0;
    end
  end

  // R10: a start always withdraws the ready flag
  a_r10_start_clears_done: assert property (@(posedge clk) disable iff (!rstN)
    startIn |=> !doneOut);

  // R9: a consumed result is no longer reported as ready
  a_r9_sync_consumes: assert property (@(posedge clk) disable iff (!rstN)
    (syncIn && doneOut) |=> !doneOut);

  // R7: ready is raised only by the multiply cycle
  a_r7_done_from_mul: assert property (@(posedge clk) disable iff (!rstN)
    (!doneOut && !strobes.mulLoad) |=> !doneOut);

  // R7: the step counter never runs past the reciprocal length
  a_r7_step_bound: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DIV) |-> (stepCnt < CNT_W'(DIV_STEPS)));

endmodule

// File: rtl/dds_datapath.sv
module dds_datapath
  import dds_pkg::*;
#(
  parameter int VW     = VOLT_W,
  parameter int VF     = VOLT_FRAC,
  parameter int DF     = DUTY_FRAC,
  parameter int RSHIFT = RECIP_SHIFT,
  parameter int NR     = NUM_RANGES
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strobes,
  input  logic [VW-1:0] ctrlVal,
  input  logic [VW-1:0] supplyV,
  output logic [DF:0]  duty1Out,
  output logic [DF:0]  duty2Out
);

  localparam int DW   = DF + 1;
  localparam int RW   = RSHIFT + 1;
  localparam int PW   = VW + RW;
  localparam int SHR  = RSHIFT - DF;
  localparam int IDXW = (NR > 1) ? $clog2(NR) : 1;
  localparam logic [DW-1:0] DUTY_ONE = DW'(1 << DF);
  localparam logic [VW-1:0] VMIN_CODE = VW'(RANGE_LO_V[0] << VF);

  logic [VW-1:0] vsReg, remReg;
  logic [RW-1:0] quotReg;
  logic          firstStep;

  logic [VW-1:0] vsClamped;
  assign vsClamped = (supplyV < VMIN_CODE) ? VMIN_CODE : supplyV;

  // serial reciprocal: floor(2^RSHIFT / vsReg), one quotient bit per step
  logic [VW:0] trial, diff;
  logic        trialGe;
  always_comb begin
    trial   = {remReg, firstStep};
    trialGe = trial >= {1'b0, vsReg};
    diff    = trial - {1'b0, vsReg};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vsReg     <= VMIN_CODE;
      remReg    <= '0;
      quotReg   <= '0;
      firstStep <= 1'b0;
    end else if (strobes.capture) begin
      vsReg     <= vsClamped;
      remReg    <= '0;
      quotReg   <= '0;
      firstStep <= 1'b1;
    end else if (strobes.divStep) begin
      remReg    <= trialGe ? diff[VW-1:0] : trial[VW-1:0];
      quotReg   <= {quotReg[RW-2:0], trialGe};
      firstStep <= 1'b0;
    end
  end

  // range comparators and per-range duty constants
  logic [NR-1:0] geVec;
  logic [DW-1:0] rangeDuty [NR];
  for (genvar g = 0; g < NR; g++) begin : g_range
    localparam logic [VW-1:0] LO_CODE = VW'(RANGE_LO_V[g] << VF);
    localparam longint RAW = (longint'(RANGE_LO_V[g]) * BETA_Q12 * REF_RECIP_Q16) >> 16;
    localparam longint CAPPED = (RAW > (longint'(1) << DF)) ? (longint'(1) << DF) : RAW;
    assign geVec[g]     = vsReg >= LO_CODE;
    assign rangeDuty[g] = DW'(CAPPED);
  end

  // linear search: the last range whose lower bound is met wins
  logic [IDXW-1:0] rangeIdx;
  always_comb begin
    rangeIdx = '0;
    for (int i = 0; i < NR; i++) begin
      if (geVec[i]) rangeIdx = IDXW'(i);
    end
  end

  // single multiply forming u * (1/vs), then saturation to 1.0
  logic [PW-1:0] prod, scaled;
  logic [DW-1:0] duty1Sat;
  always_comb begin
    prod     = {{RW{1'b0}}, ctrlVal} * {{VW{1'b0}}, quotReg};
    scaled   = prod >> SHR;
    duty1Sat = (scaled > PW'(DUTY_ONE)) ? DUTY_ONE : scaled[DW-1:0];
  end

  logic [DW-1:0] pend1, pend2;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend1 <= '0;
      pend2 <= '0;
    end else if (strobes.mulLoad) begin
      pend1 <= duty1Sat;
      pend2 <= rangeDuty[rangeIdx];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      duty1Out <= '0;
      duty2Out <= '0;
    end else if (strobes.apply) begin
      duty1Out <= pend1;
      duty2Out <= pend2;
    end
  end

  // R8: outputs move only on an applying sync
  a_r8_hold_without_apply: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.apply |=> ($stable(duty1Out) && $stable(duty2Out)));

  // R6: stage-one duty never exceeds 1.0
  a_r6_duty1_bounded: assert property (@(posedge clk) disable iff (!rstN)
    duty1Out <= DUTY_ONE);

  // R5: stage-two duty never exceeds 1.0
  a_r5_duty2_bounded: assert property (@(posedge clk) disable iff (!rstN)
    duty2Out <= DUTY_ONE);

  // R3: the captured supply is never below the clamp floor
  a_r3_clamp_floor: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> (vsReg >= VMIN_CODE));

endmodule

// File: rtl/dual_duty_shaper.sv
module dual_duty_shaper
  import dds_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startIn,
  input  logic [VOLT_W-1:0]    ctrlVal,
  input  logic [VOLT_W-1:0]    supplyV,
  input  logic                 syncIn,
  output logic [DUTY_FRAC:0]   duty1Out,
  output logic [DUTY_FRAC:0]   duty2Out,
  output logic                 doneOut
);

  ctrlStrobes_t strobes;

  dds_ctrl #(
    .DIV_STEPS(RECIP_SHIFT + 1)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .startIn (startIn),
    .syncIn  (syncIn),
    .strobes (strobes),
    .doneOut (doneOut)
  );

  dds_datapath #(
    .VW     (VOLT_W),
    .VF     (VOLT_FRAC),
    .DF     (DUTY_FRAC),
    .RSHIFT (RECIP_SHIFT),
    .NR     (NUM_RANGES)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .ctrlVal  (ctrlVal),
    .supplyV  (supplyV),
    .duty1Out (duty1Out),
    .duty2Out (duty2Out)
  );

endmodule

// File: tb/dual_duty_shaper_tb_top.sv
module dual_duty_shaper_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 26;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startIn = 1'b0;
  logic [13:0] ctrlVal = '0;
  logic [13:0] supplyV = '0;
  logic        syncIn = 1'b0;
  logic [12:0] duty1Out, duty2Out;
  logic        doneOut;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  string curReq = "R1";

  dual_duty_shaper dut_i (
    .clk(clk), .rstN(rstN), .startIn(startIn), .ctrlVal(ctrlVal),
    .supplyV(supplyV), .syncIn(syncIn), .duty1Out(duty1Out),
    .duty2Out(duty2Out), .doneOut(doneOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int clampVs(int vs);
    return (vs < 2560) ? 2560 : vs;
  endfunction

  function automatic int expD1(int u, int vs);
    longint r, p;
    r = (longint'(1) << 24) / clampVs(vs);
    p = (longint'(u) * r) >> 12;
    return (p > 4096) ? 4096 : int'(p);
  endfunction

  function automatic int expD2(int vs);
    int c;
    c = clampVs(vs);
    if (c >= 5376) return 4085;
    if (c >= 4608) return 3502;
    if (c >= 4096) return 3112;
    if (c >= 3584) return 2723;
    if (c >= 3072) return 2334;
    return 1945;
  endfunction

  // behavioural reference model
  int mCnt = 0, mVs = 0, mP1 = 0, mP2 = 0, mOut1 = 0, mOut2 = 0;
  bit mDone = 0;
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rstN) begin
      mCnt <= 0; mVs <= 0; mP1 <= 0; mP2 <= 0;
      mOut1 <= 0; mOut2 <= 0; mDone <= 0;
    end else begin
      if (syncIn && mDone) begin
        mOut1 <= mP1;
        mOut2 <= mP2;
      end
      if (startIn) begin
        mCnt  <= LAT;
        mVs   <= int'(supplyV);
        mDone <= 0;
      end else if (mCnt == 1) begin
        mP1   <= expD1(int'(ctrlVal), mVs);
        mP2   <= expD2(mVs);
        mDone <= 1;
        mCnt  <= 0;
      end else begin
        if (mCnt > 1) mCnt <= mCnt - 1;
        if (syncIn && mDone) mDone <= 0;
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN) begin
      checks++;
      if (int'(duty1Out) != mOut1 || int'(duty2Out) != mOut2 || doneOut != mDone) begin
        errors++;
        $display("FAIL %s cycle %0d: d1=%0d d2=%0d done=%0d expected d1=%0d d2=%0d done=%0d",
                 curReq, cycles, duty1Out, duty2Out, doneOut, mOut1, mOut2, mDone);
      end
    end
  end

  task automatic checkVal(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulseStart(int u, int vs);
    @(negedge clk);
    ctrlVal = 14'(u); supplyV = 14'(vs); startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
  endtask

  task automatic pulseSync();
    @(negedge clk);
    syncIn = 1'b1;
    @(negedge clk);
    syncIn = 1'b0;
  endtask

  task automatic runCase(string req, int u, int vs, int e1, int e2);
    curReq = req;
    pulseStart(u, vs);
    repeat (LAT - 1) @(negedge clk);
    checkVal({req, " done not yet"}, int'(doneOut), 0);
    @(negedge clk);
    checkVal({req, " done latency"}, int'(doneOut), 1);
    pulseSync();
    checkVal({req, " duty1"}, int'(duty1Out), e1);
    checkVal({req, " duty2"}, int'(duty2Out), e2);
    checkVal({req, " done cleared"}, int'(doneOut), 0);
  endtask

  initial begin : watchdog
    wait (cycles > WATCHDOG);
    errors++;
    $display("FAIL watchdog: actual=%0d cycles expected=<%0d", cycles, WATCHDOG);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    checkVal("R1 duty1 reset", int'(duty1Out), 0);
    checkVal("R1 duty2 reset", int'(duty2Out), 0);
    checkVal("R1 done reset", int'(doneOut), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R11: sync with nothing pending
    curReq = "R11";
    pulseSync();
    checkVal("R11 duty1 unchanged", int'(duty1Out), 0);
    checkVal("R11 duty2 unchanged", int'(duty2Out), 0);

    // R2, R5: 8 V over 16.5 V
    runCase("R2", 2048, 4224, 1985, 3112);
    // R3: 4 V with supply 5 V clamped to 10 V
    runCase("R3", 1024, 1280, 1638, 1945);
    // R4: exactly on 12 V bound and one LSB under
    runCase("R4 on-bound", 1024, 3072, expD1(1024, 3072), 2334);
    runCase("R4 under-bound", 1024, 3071, expD1(1024, 3071), 1945);
    runCase("R4 21V", 2000, 5376, expD1(2000, 5376), 4085);
    runCase("R4 31V", 2000, 7936, expD1(2000, 7936), 4085);
    runCase("R5 14V", 1500, 3600, expD1(1500, 3600), 2723);
    runCase("R5 18V", 1500, 4700, expD1(1500, 4700), 3502);
    // R6: saturation, and exact 1.0
    runCase("R6 sat", 3840, 3072, 4096, 2334);
    runCase("R6 unity", 4096, 4096, 4096, 3112);

    // R8: results wait without sync
    curReq = "R8";
    pulseStart(1000, 4000);
    repeat (LAT + 10) @(negedge clk);
    checkVal("R8 held duty1", int'(duty1Out), 4096);
    checkVal("R8 held duty2", int'(duty2Out), 3112);
    checkVal("R8 done waiting", int'(doneOut), 1);
    pulseSync();
    checkVal("R9 applied duty1", int'(duty1Out), expD1(1000, 4000));
    checkVal("R9 applied duty2", int'(duty2Out), 2723);

    // R10: restart mid-computation, then restart over a pending result
    curReq = "R10";
    pulseStart(500, 2600);
    repeat (8) @(negedge clk);
    pulseStart(1200, 5000);
    repeat (LAT) @(negedge clk);
    checkVal("R10 pending after restart", int'(doneOut), 1);
    pulseStart(700, 3300);
    checkVal("R10 done cleared", int'(doneOut), 0);
    pulseSync();
    checkVal("R10 sync before result duty1", int'(duty1Out), expD1(1000, 4000));
    checkVal("R10 sync before result duty2", int'(duty2Out), 2723);
    repeat (LAT) @(negedge clk);
    pulseSync();
    checkVal("R10 new duty1", int'(duty1Out), expD1(700, 3300));
    checkVal("R10 new duty2", int'(duty2Out), 2334);

    // R7: ctrlVal sampled on the multiply edge, not at start
    curReq = "R7";
    pulseStart(100, 4096);
    ctrlVal = 14'd2048;
    repeat (LAT) @(negedge clk);
    pulseSync();
    checkVal("R7 late ctrlVal duty1", int'(duty1Out), 2048);

    // R9: start and sync together with a pending result
    curReq = "R9";
    pulseStart(3000, 6000);
    repeat (LAT) @(negedge clk);
    @(negedge clk);
    ctrlVal = 14'd1000; supplyV = 14'd3000; startIn = 1'b1; syncIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0; syncIn = 1'b0;
    checkVal("R9 start+sync duty1", int'(duty1Out), expD1(3000, 6000));
    checkVal("R9 start+sync done", int'(doneOut), 0);
    repeat (LAT + 2) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule